// File: doc/BRIEF.md
# Byte-Addressed Digital I/O Register File

This block sits behind a byte-wide host bus and exposes sixteen byte locations that control a bank of digital lines. Three writable bytes drive 24 output lines. Three read-only bytes return the synchronised levels of 24 isolated input lines. An eight-line TTL port can be turned as a whole into an output port or an input port by one control bit. Every writable byte reads back its stored value, so software can use read-modify-write sequences on single bits.

The change-of-state locations (offsets 8 to 11 and 14) are not implemented here. Accesses to them are decoded and forwarded to an external port, and their read data is taken from that port. Any write to offset 15 clears every register of this block in the following cycle and is also signalled outward, so the external change-of-state logic can clear itself too. A read of offset 15 returns the interrupt pin level in bit 0.

Reads are registered: the byte selected at the clock edge where the read strobe is high appears on the read data port after that edge and is held until the next read.

Top module: `dio_regfile`

## Requirements
- R1: After reset every register is 0: `out_o` is 0, `ttl_oe_o` is 0 (TTL port in input mode) and `rdata_o` is 0.
- R2: A write to offset k (k = 0, 1, 2) stores the byte; bit n of it drives `out_o[8*k+n]` from the next cycle, and a read of offset k returns the stored byte.
- R3: Offsets 4, 5 and 6 return `in_i[7:0]`, `in_i[15:8]` and `in_i[23:16]` after a two-stage synchroniser: a read whose sampling edge is the second edge after an input change returns the old value, the third edge returns the new one. Writes to offsets 4 to 7 change no register and no output.
- R4: Bit 1 of the control byte (offset 12) selects the TTL direction: 1 sets all eight bits of `ttl_oe_o` and drives `ttl_o` from the TTL output byte at offset 3; 0 clears all eight bits of `ttl_oe_o`.
- R5: A read of offset 7 returns the TTL output byte when control bit 1 is 1, and the synchronised `ttl_i` levels when it is 0.
- R6: The full control byte at offset 12 is writable and reads back exactly what was written.
- R7: Any write to offset 15 asserts `soft_rst_o` in that cycle and, from the next cycle, clears the output bytes, the TTL output byte and the control byte.
- R8: Reads of offset 13 return 0 and writes to it change nothing; a read of offset 15 returns `{7'b0, irq_i}`.
- R9: Accesses to offsets 8, 9, 10, 11 and 14 assert `ext_wr_o` or `ext_rd_o` in the same cycle and a read there returns `ext_rdata_i`; no other offset asserts these strobes.
- R10: `rdata_o` changes only after an edge where `rd_i` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Byte offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| out_o | output | 24 | Output lines |
| in_i | input | 24 | Isolated input lines (asynchronous) |
| ttl_i | input | 8 | TTL pin levels (asynchronous) |
| ttl_o | output | 8 | TTL drive values |
| ttl_oe_o | output | 8 | TTL output enables |
| irq_i | input | 1 | Interrupt pin level, read at offset 15 |
| ext_addr_o | output | 4 | Offset forwarded to change-of-state logic |
| ext_wdata_o | output | 8 | Write data forwarded to change-of-state logic |
| ext_wr_o | output | 1 | Write strobe for change-of-state offsets |
| ext_rd_o | output | 1 | Read strobe for change-of-state offsets |
| ext_rdata_i | input | 8 | Read data from change-of-state logic |
| soft_rst_o | output | 1 | Software reset pulse |

## Verification
A wrong byte register shows at once on `out_o`, `ttl_o` or `ttl_oe_o` in the cycle after the write, and on `rdata_o` one cycle after a read of that offset. A broken synchroniser depth shows as the new input value appearing one read too early or too late, which the bench pins to a specific edge. A decode error on the reserved, read-only or pass-through offsets shows as an output or read-back byte that moved after a write that should have had no effect, or as an external strobe in the wrong cycle.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam int OFF_OUT0    = 0;
  localparam int OFF_TTL_OUT = 3;
  localparam int OFF_IN0     = 4;
  localparam int OFF_TTL_IN  = 7;
  localparam int OFF_CTL     = 12;
  localparam int OFF_RSVD    = 13;
  localparam int OFF_SRST    = 15;

  localparam int CTL_TTL_DIR = 1;

  function automatic logic is_ext_off(input logic [ADDR_W-1:0] a);
    return (a inside {4'd8, 4'd9, 4'd10, 4'd11, 4'd14});
  endfunction
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dio_wr_bank.sv
module dio_wr_bank #(
  parameter int BYTES  = 3,
  parameter int BASE   = 0,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int W     = BYTES * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  output logic [W-1:0]      q_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(BASE + b);
    logic [DATA_W-1:0] byte_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        byte_q <= '0;
      else if (clr_i)                     byte_q <= '0;
      else if (wr_i && addr_i == MY_OFF)  byte_q <= wdata_i;
    end

    assign q_o[b*DATA_W +: DATA_W] = byte_q;
  end
endmodule

// File: rtl/dio_rd_mux.sv
module dio_rd_mux
  import dio_pkg::*;
#(
  parameter int OUT_BYTES = 3,
  parameter int IN_BYTES  = 3
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [OUT_BYTES*DATA_W-1:0] out_q_i,
  input  logic [IN_BYTES*DATA_W-1:0]  in_q_i,
  input  logic [DATA_W-1:0]           ttl_out_q_i,
  input  logic [DATA_W-1:0]           ttl_in_q_i,
  input  logic [DATA_W-1:0]           ctl_q_i,
  input  logic                        irq_i,
  input  logic [DATA_W-1:0]           ext_rdata_i,
  output logic [DATA_W-1:0]           rd_val_o
);
  logic ttl_out_mode;
  assign ttl_out_mode = ctl_q_i[CTL_TTL_DIR];

  always_comb begin
    rd_val_o = '0;
    for (int b = 0; b < OUT_BYTES; b++) begin
      if (addr_i == ADDR_W'(OFF_OUT0 + b)) rd_val_o = out_q_i[b*DATA_W +: DATA_W];
    end
    for (int b = 0; b < IN_BYTES; b++) begin
      if (addr_i == ADDR_W'(OFF_IN0 + b)) rd_val_o = in_q_i[b*DATA_W +: DATA_W];
    end
    if (addr_i == ADDR_W'(OFF_TTL_OUT)) rd_val_o = ttl_out_q_i;
    if (addr_i == ADDR_W'(OFF_TTL_IN))  rd_val_o = ttl_out_mode ? ttl_out_q_i : ttl_in_q_i;
    if (addr_i == ADDR_W'(OFF_CTL))     rd_val_o = ctl_q_i;
    if (addr_i == ADDR_W'(OFF_SRST))    rd_val_o = {{(DATA_W-1){1'b0}}, irq_i};
    if (is_ext_off(addr_i))             rd_val_o = ext_rdata_i;
  end
endmodule

// File: rtl/dio_regfile.sv
module dio_regfile
  import dio_pkg::*;
#(
  parameter int OUT_BYTES   = 3,
  parameter int IN_BYTES    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int OUT_W      = OUT_BYTES * DATA_W,
  localparam int IN_W       = IN_BYTES * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [OUT_W-1:0]  out_o,
  input  logic [IN_W-1:0]   in_i,
  input  logic [DATA_W-1:0] ttl_i,
  output logic [DATA_W-1:0] ttl_o,
  output logic [DATA_W-1:0] ttl_oe_o,
  input  logic              irq_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  output logic              ext_wr_o,
  output logic              ext_rd_o,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic              soft_rst_o
);
  logic [OUT_W-1:0]  out_q;
  logic [IN_W-1:0]   in_q;
  logic [DATA_W-1:0] ttl_out_q, ttl_in_q, ctl_q, rd_val, rdata_q;
  logic              srst;

  assign srst = wr_i && (addr_i == ADDR_W'(OFF_SRST));

  dio_wr_bank #(.BYTES(OUT_BYTES), .BASE(OFF_OUT0), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .clr_i(srst), .q_o(out_q)
  );

  dio_wr_bank #(.BYTES(1), .BASE(OFF_TTL_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ttl (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .clr_i(srst), .q_o(ttl_out_q)
  );

  dio_wr_bank #(.BYTES(1), .BASE(OFF_CTL), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .clr_i(srst), .q_o(ctl_q)
  );

  dio_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i, .rst_ni, .d_i(in_i), .q_o(in_q)
  );

  dio_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_ttl_sync (
    .clk_i, .rst_ni, .d_i(ttl_i), .q_o(ttl_in_q)
  );

  dio_rd_mux #(.OUT_BYTES(OUT_BYTES), .IN_BYTES(IN_BYTES)) u_rd_mux (
    .addr_i,
    .out_q_i    (out_q),
    .in_q_i     (in_q),
    .ttl_out_q_i(ttl_out_q),
    .ttl_in_q_i (ttl_in_q),
    .ctl_q_i    (ctl_q),
    .irq_i,
    .ext_rdata_i,
    .rd_val_o   (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o     = rdata_q;
  assign out_o       = out_q;
  assign ttl_o       = ttl_out_q;
  assign ttl_oe_o    = {DATA_W{ctl_q[CTL_TTL_DIR]}};
  assign ext_addr_o  = addr_i;
  assign ext_wdata_o = wdata_i;
  assign ext_wr_o    = wr_i && is_ext_off(addr_i);
  assign ext_rd_o    = rd_i && is_ext_off(addr_i);
  assign soft_rst_o  = srst;
endmodule

// File: rtl/dio_regfile_chk.sv
module dio_regfile_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  addr_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input logic [23:0] out_o,
  input logic [7:0]  ttl_o,
  input logic [7:0]  ttl_oe_o,
  input logic        soft_rst_o
);
  assert_out_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'd0) |=> (out_o[7:0] == $past(wdata_i)));

  assert_ro_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd13})
      |=> ($stable(out_o) && $stable(ttl_o) && $stable(ttl_oe_o)));

  assert_ttl_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'd12) |=> (ttl_oe_o == {8{$past(wdata_i[1])}}));

  assert_soft_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (out_o == '0 && ttl_o == '0 && ttl_oe_o == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind dio_regfile dio_regfile_chk u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
  .out_o, .ttl_o, .ttl_oe_o, .soft_rst_o
);

// File: tb/tb_dio_regfile.sv
module tb_dio_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] out_l;
  logic [23:0] in_l = '0;
  logic [7:0]  ttl_in = '0;
  logic [7:0]  ttl_out, ttl_oe;
  logic        irq = 1'b0;
  logic [3:0]  ext_addr;
  logic [7:0]  ext_wdata, ext_rdata;
  logic        ext_wr, ext_rd, soft_rst;

  int n_checks = 0;
  int n_fail   = 0;

  assign ext_rdata = {4'h5, ext_addr};

  always #(CLK_PERIOD/2) clk = ~clk;

  dio_regfile dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .out_o(out_l), .in_i(in_l),
    .ttl_i(ttl_in), .ttl_o(ttl_out), .ttl_oe_o(ttl_oe), .irq_i(irq),
    .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata), .ext_wr_o(ext_wr),
    .ext_rd_o(ext_rd), .ext_rdata_i(ext_rdata), .soft_rst_o(soft_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    check("R1 out_o", 32'(out_l), 0);
    check("R1 ttl_oe_o", 32'(ttl_oe), 0);
    check("R1 rdata_o", 32'(rdata), 0);
    bus_read(4'd12, d);
    check("R1 control byte", 32'(d), 0);
  endtask

  task automatic t_output_bytes();
    logic [7:0] d;
    bus_write(4'd0, 8'hA5);
    check("R2 out_o after byte0", 32'(out_l), 32'h0000A5);
    bus_write(4'd1, 8'h3C);
    bus_write(4'd2, 8'h81);
    check("R2 out_o all bytes", 32'(out_l), 32'h813CA5);
    check("R2 line 23", 32'(out_l[23]), 1);
    check("R2 line 8", 32'(out_l[8]), 0);
    bus_read(4'd1, d);
    check("R2 readback byte1", 32'(d), 32'h3C);
    bus_read(4'd2, d);
    check("R2 readback byte2", 32'(d), 32'h81);
  endtask

  task automatic t_inputs();
    logic [7:0] d;
    in_l = 24'h123456;
    idle(4);
    bus_read(4'd4, d); check("R3 in byte0", 32'(d), 32'h56);
    bus_read(4'd5, d); check("R3 in byte1", 32'(d), 32'h34);
    bus_read(4'd6, d); check("R3 in byte2", 32'(d), 32'h12);
    // change at a negedge; the read samples on the second edge afterwards
    @(negedge clk); in_l = 24'h12AB56;
    bus_read(4'd5, d); check("R3 sync latency old", 32'(d), 32'h34);
    bus_read(4'd5, d); check("R3 sync latency new", 32'(d), 32'hAB);
    for (int a = 4; a < 8; a++) bus_write(4'(a), 8'hFF);
    check("R3 ro writes keep out_o", 32'(out_l), 32'h813CA5);
    check("R3 ro writes keep ttl_oe", 32'(ttl_oe), 0);
    bus_read(4'd0, d); check("R3 ro writes keep byte0", 32'(d), 32'hA5);
    bus_read(4'd12, d); check("R3 ro writes keep control", 32'(d), 0);
    bus_read(4'd4, d); check("R3 in byte0 after write", 32'(d), 32'h56);
  endtask

  task automatic t_ttl();
    logic [7:0] d;
    bus_write(4'd12, 8'hF5);
    bus_read(4'd12, d); check("R6 control readback F5", 32'(d), 32'hF5);
    check("R4 bit1 clear input mode", 32'(ttl_oe), 0);
    bus_write(4'd12, 8'h02);
    bus_read(4'd12, d); check("R6 control readback 02", 32'(d), 32'h02);
    check("R4 output mode oe", 32'(ttl_oe), 32'hFF);
    bus_write(4'd3, 8'h9C);
    check("R4 ttl_o drive", 32'(ttl_out), 32'h9C);
    ttl_in = 8'h33;
    idle(4);
    bus_read(4'd7, d); check("R5 output mode read", 32'(d), 32'h9C);
    bus_write(4'd12, 8'h00);
    check("R4 back to input mode", 32'(ttl_oe), 0);
    bus_read(4'd7, d); check("R5 input mode read", 32'(d), 32'h33);
    bus_read(4'd3, d); check("R5 ttl byte kept", 32'(d), 32'h9C);
  endtask

  task automatic t_misc_offsets();
    logic [7:0] d;
    bus_write(4'd13, 8'hFF);
    bus_read(4'd13, d); check("R8 reserved reads 0", 32'(d), 0);
    check("R8 reserved write no effect", 32'(out_l), 32'h813CA5);
    irq = 1'b1;
    bus_read(4'd15, d); check("R8 irq high", 32'(d), 1);
    irq = 1'b0;
    bus_read(4'd15, d); check("R8 irq low", 32'(d), 0);
  endtask

  task automatic t_ext();
    logic [7:0] d;
    @(negedge clk); addr = 4'd9; wdata = 8'h77; wr = 1'b1;
    #1;
    check("R9 ext_wr at 9", 32'(ext_wr), 1);
    check("R9 ext_wdata", 32'(ext_wdata), 32'h77);
    @(negedge clk); addr = 4'd14; wr = 1'b1;
    #1; check("R9 ext_wr at 14", 32'(ext_wr), 1);
    @(negedge clk); addr = 4'd3; wdata = 8'h9C; wr = 1'b1;
    #1; check("R9 no ext_wr at 3", 32'(ext_wr), 0);
    @(negedge clk); wr = 1'b0; addr = 4'd12; rd = 1'b1;
    #1; check("R9 no ext_rd at 12", 32'(ext_rd), 0);
    @(negedge clk); addr = 4'd10; rd = 1'b1;
    #1; check("R9 ext_rd at 10", 32'(ext_rd), 1);
    @(negedge clk); rd = 1'b0; d = rdata;
    check("R9 ext read data", 32'(d), 32'h5A);
    check("R9 ext write no local effect", 32'(out_l), 32'h813CA5);
  endtask

  task automatic t_read_hold();
    logic [7:0] d;
    bus_read(4'd0, d);
    check("R10 read value", 32'(d), 32'hA5);
    @(negedge clk); addr = 4'd2;
    @(negedge clk); addr = 4'd15;
    @(negedge clk);
    check("R10 rdata held", 32'(rdata), 32'hA5);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d;
    bus_write(4'd12, 8'h06);
    bus_write(4'd3, 8'h5A);
    check("R7 pre oe", 32'(ttl_oe), 32'hFF);
    @(negedge clk); addr = 4'd15; wdata = 8'h00; wr = 1'b1;
    #1; check("R7 soft_rst_o pulse", 32'(soft_rst), 1);
    @(negedge clk); wr = 1'b0;
    #1; check("R7 soft_rst_o drops", 32'(soft_rst), 0);
    check("R7 out_o cleared", 32'(out_l), 0);
    check("R7 ttl_oe cleared", 32'(ttl_oe), 0);
    check("R7 ttl_o cleared", 32'(ttl_out), 0);
    bus_read(4'd12, d); check("R7 control cleared", 32'(d), 0);
    bus_read(4'd3, d);  check("R7 ttl byte cleared", 32'(d), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset_state();
    t_output_bytes();
    t_inputs();
    t_ttl();
    t_misc_offsets();
    t_ext();
    t_read_hold();
    t_soft_reset();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule